// File: doc/BRIEF.md
# Prioritized Interrupt Event Controller

This block sits beside a processor core and decides when the core must leave its current instruction stream to run a handler. It tracks sixteen priority levels, numbered 0 to 15, where a smaller number is more urgent. Requests arrive from external request lines or from a software raise command. They collect in a pending register, are filtered by an enable mask, and are compared against the set of levels already in service. When a level wins, the block pulses a take output together with the level number and the handler address read from an internal vector table. It also saves the interrupted address in a return register.

The core signals return-from-interrupt with a strobe. The block then gives back the saved address with bit 0 forced low and normally retires the most urgent in-service level. Bit 0 of the return register marks an entry that nested into the same level. When that bit is set on return, the in-service bit is kept. Software can set the bit by writing the return register. A configuration bit decides whether the level in service may be entered again by its own request. A global enable flag, cleared on every entry and set again on every return, gates all entries. A nesting-enable input lets a running handler be preempted by more urgent levels.

All registers and the vector table are reached through a byte-addressed write port and a read port. The read port returns data one cycle after the address is presented.

Top module: `evt_ctrl`

## Requirements
- R1: After reset the pending, mask and in-service registers read 0, and the control register reads 1 (bit 0 = global enable set, bit 2 = self-nest clear). take_o and resume_o are low.
- R2: A raise strobe with level N sets pending bit N. A high bit on req_i sets the matching pending bit. Raises issued on consecutive cycles all stay pending together. Writing offset 0x00 replaces the pending register.
- R3: A pending level whose mask bit (offset 0x04, bit N = level N) is 0 stays pending and is never taken.
- R4: One clock edge after a level becomes eligible, take_o pulses for one cycle with take_lvl_o = N and take_vec_o = vector entry N. On that same edge in-service bit N (offset 0x08) is set, pending bit N is cleared, and the global enable is cleared.
- R5: On an entry into a level that is not already in service, the return register (offset 0x10) is loaded with ret_addr_i with bit 0 forced to 0.
- R6: Among pending, enabled levels the lowest number is chosen. It is taken only if its number is strictly below the lowest-numbered in-service level, or if no level is in service.
- R7: Entry needs the global enable, or nest_en_i high while some level is in service. Otherwise no take occurs.
- R8: With self-nesting off (control bit 2 = 0), raising the level in service does not re-enter it. The request stays pending and is taken after that level returns.
- R9: With self-nesting on, raising the level in service re-enters it, and bit 0 of the return register is set to 1.
- R10: On a return strobe, resume_o pulses on the next edge with resume_addr_o = return register with bit 0 cleared. If bit 0 of the return register was 1, the in-service register is unchanged.
- R11: On a return with bit 0 of the return register clear, the lowest-numbered in-service bit is cleared and the global enable is set. A pending level less urgent than the one retired may then be taken.
- R12: Vector entry N sits at byte offset 0x40 + 4*N and can be written and read back. The return register can be written at 0x10. Read data appears one cycle after the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 16 | External request lines, one per level |
| raise_i | input | 1 | Software raise strobe |
| raise_lvl_i | input | 4 | Level named by the raise strobe |
| rti_i | input | 1 | Return-from-interrupt strobe |
| ret_addr_i | input | 32 | Address of the interrupted instruction |
| nest_en_i | input | 1 | Allows preemption while a handler runs |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 7 | Register write byte address |
| wr_data_i | input | 32 | Register write data |
| rd_addr_i | input | 7 | Register read byte address |
| rd_data_o | output | 32 | Read data, one cycle after the address |
| take_o | output | 1 | One-cycle pulse: enter a handler |
| take_lvl_o | output | 4 | Level being entered |
| take_vec_o | output | 32 | Handler address for the entered level |
| resume_o | output | 1 | One-cycle pulse: return completed |
| resume_addr_o | output | 32 | Address to resume at, bit 0 clear |

## Verification
A corrupted in-service set would show up as a missing or extra take on the very next edge after a raise, or after the following return. A wrong return-register bit 0 shows up as a kept or lost in-service bit that is visible through the read port one cycle after the return. The bench sweeps every level through raise, entry and return. It reads the pending, in-service and return registers straight after each event, so any stale or misplaced bit is caught within two cycles of the event that caused it.

// File: rtl/ec_pkg.sv
`timescale 1ns/1ps
package ec_pkg;
  // byte offsets inside the register region
  localparam int OFF_PEND   = 'h00;
  localparam int OFF_MASK   = 'h04;
  localparam int OFF_ACTIVE = 'h08;
  localparam int OFF_CTRL   = 'h0C;
  localparam int OFF_RET    = 'h10;
  // control register fields
  localparam int CTRL_GIE   = 0;
  localparam int CTRL_SNEST = 2;

  typedef enum logic [2:0] {
    SEL_PEND, SEL_MASK, SEL_ACTIVE, SEL_CTRL, SEL_RET, SEL_NONE
  } reg_sel_e;
endpackage

// File: rtl/ec_prio.sv
`timescale 1ns/1ps
module ec_prio #(
  parameter int N = 16,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  vec_i,
  output logic          hit_o,
  output logic [IW-1:0] idx_o
);
  // lowest set index wins
  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec_i[i]) begin
        hit_o = 1'b1;
        idx_o = IW'(i);
      end
    end
  end
endmodule

// File: rtl/ec_vec_table.sv
`timescale 1ns/1ps
module ec_vec_table #(
  parameter int DEPTH = 16,
  parameter int DW    = 32,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we_i,
  input  logic [IW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          re_a_i,
  input  logic [IW-1:0] raddr_a_i,
  output logic [DW-1:0] rdata_a_o,
  input  logic [IW-1:0] raddr_b_i,
  output logic [DW-1:0] rdata_b_o
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  always_ff @(posedge clk) begin
    if (re_a_i) rdata_a_o <= mem[raddr_a_i];
  end

  always_ff @(posedge clk) begin
    rdata_b_o <= mem[raddr_b_i];
  end
endmodule

// File: rtl/evt_ctrl.sv
`timescale 1ns/1ps
module evt_ctrl
  import ec_pkg::*;
#(
  parameter int LVLS = 16,
  parameter int AW   = 32,
  parameter int RA_W = 7,
  localparam int LW  = $clog2(LVLS)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [LVLS-1:0] req_i,
  input  logic            raise_i,
  input  logic [LW-1:0]   raise_lvl_i,
  input  logic            rti_i,
  input  logic [AW-1:0]   ret_addr_i,
  input  logic            nest_en_i,
  input  logic            wr_en_i,
  input  logic [RA_W-1:0] wr_addr_i,
  input  logic [AW-1:0]   wr_data_i,
  input  logic [RA_W-1:0] rd_addr_i,
  output logic [AW-1:0]   rd_data_o,
  output logic            take_o,
  output logic [LW-1:0]   take_lvl_o,
  output logic [AW-1:0]   take_vec_o,
  output logic            resume_o,
  output logic [AW-1:0]   resume_addr_o
);
  localparam int VB = RA_W - 1;   // address bit selecting the vector table

  function automatic reg_sel_e decode(input logic [RA_W-1:0] a);
    if (a[VB])                          return SEL_NONE;
    if (a[VB-1:0] == VB'(OFF_PEND))     return SEL_PEND;
    if (a[VB-1:0] == VB'(OFF_MASK))     return SEL_MASK;
    if (a[VB-1:0] == VB'(OFF_ACTIVE))   return SEL_ACTIVE;
    if (a[VB-1:0] == VB'(OFF_CTRL))     return SEL_CTRL;
    if (a[VB-1:0] == VB'(OFF_RET))      return SEL_RET;
    return SEL_NONE;
  endfunction

  logic [LVLS-1:0] pend_q, mask_q, isr_q;
  logic [AW-1:0]   ret_q;
  logic            gie_q, sn_q;

  // ---------------- priority resolution ----------------
  logic          pend_hit, act_hit;
  logic [LW-1:0] pend_lvl, act_lvl;

  ec_prio #(.N(LVLS)) u_pend_prio (
    .vec_i (pend_q & mask_q),
    .hit_o (pend_hit),
    .idx_o (pend_lvl)
  );

  ec_prio #(.N(LVLS)) u_act_prio (
    .vec_i (isr_q),
    .hit_o (act_hit),
    .idx_o (act_lvl)
  );

  logic ent_ok, preempt, self_ok, take_now;
  always_comb begin
    ent_ok   = gie_q | (nest_en_i & act_hit);
    preempt  = !act_hit || (pend_lvl < act_lvl);
    self_ok  = sn_q && act_hit && (pend_lvl == act_lvl);
    take_now = !rti_i && pend_hit && ent_ok && (preempt || self_ok);
  end

  // ---------------- write decode ----------------
  reg_sel_e wsel;
  logic     wr_vec;
  always_comb begin
    wsel   = wr_en_i ? decode(wr_addr_i) : SEL_NONE;
    wr_vec = wr_en_i && wr_addr_i[VB];
  end

  logic [LVLS-1:0] raise_bits, take_bits, act_bits, pend_base;
  always_comb begin
    raise_bits = raise_i  ? (LVLS'(1) << raise_lvl_i) : '0;
    take_bits  = take_now ? (LVLS'(1) << pend_lvl)    : '0;
    act_bits   = LVLS'(1) << act_lvl;
    pend_base  = (wsel == SEL_PEND) ? wr_data_i[LVLS-1:0] : pend_q;
  end

  // ---------------- state ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      mask_q <= '0;
      isr_q  <= '0;
      ret_q  <= '0;
      gie_q  <= 1'b1;
      sn_q   <= 1'b0;
    end else begin
      pend_q <= (pend_base & ~take_bits) | raise_bits | req_i;
      if (wsel == SEL_MASK) mask_q <= wr_data_i[LVLS-1:0];

      if (take_now)
        isr_q <= isr_q | take_bits;
      else if (rti_i && !ret_q[0] && act_hit)
        isr_q <= isr_q & ~act_bits;

      if (take_now)
        ret_q <= (ret_addr_i & ~AW'(1)) | AW'(self_ok);
      else if (wsel == SEL_RET)
        ret_q <= wr_data_i;

      if (take_now)             gie_q <= 1'b0;
      else if (rti_i)           gie_q <= 1'b1;
      else if (wsel == SEL_CTRL) gie_q <= wr_data_i[CTRL_GIE];

      if (wsel == SEL_CTRL) sn_q <= wr_data_i[CTRL_SNEST];
    end
  end

  // ---------------- vector table ----------------
  logic [AW-1:0] vec_b;

  ec_vec_table #(.DEPTH(LVLS), .DW(AW)) u_vec (
    .clk       (clk),
    .we_i      (wr_vec),
    .waddr_i   (wr_addr_i[LW+1:2]),
    .wdata_i   (wr_data_i),
    .re_a_i    (take_now),
    .raddr_a_i (pend_lvl),
    .rdata_a_o (take_vec_o),
    .raddr_b_i (rd_addr_i[LW+1:2]),
    .rdata_b_o (vec_b)
  );

  // ---------------- event outputs ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      take_o        <= 1'b0;
      take_lvl_o    <= '0;
      resume_o      <= 1'b0;
      resume_addr_o <= '0;
    end else begin
      take_o   <= take_now;
      resume_o <= rti_i;
      if (take_now) take_lvl_o <= pend_lvl;
      if (rti_i)    resume_addr_o <= {ret_q[AW-1:1], 1'b0};
    end
  end

  // ---------------- read port ----------------
  logic [AW-1:0] reg_rd_q;
  logic          vec_rd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rd_q <= '0;
      vec_rd_q <= 1'b0;
    end else begin
      vec_rd_q <= rd_addr_i[VB];
      unique case (decode(rd_addr_i))
        SEL_PEND:   reg_rd_q <= AW'(pend_q);
        SEL_MASK:   reg_rd_q <= AW'(mask_q);
        SEL_ACTIVE: reg_rd_q <= AW'(isr_q);
        SEL_CTRL:   reg_rd_q <= AW'({sn_q, 1'b0, gie_q});
        SEL_RET:    reg_rd_q <= ret_q;
        default:    reg_rd_q <= '0;
      endcase
    end
  end

  assign rd_data_o = vec_rd_q ? vec_b : reg_rd_q;

  // ---------------- assertions ----------------
  for (genvar L = 0; L < LVLS; L++) begin : g_lvl_chk
    AST_TAKE_UNMASKED: assert property (@(posedge clk) disable iff (rst)
      (take_o && take_lvl_o == LW'(L)) |-> $past(mask_q[L]));                  // R3
    AST_ACTIVE_ON_TAKE: assert property (@(posedge clk) disable iff (rst)
      (take_o && take_lvl_o == LW'(L)) |-> isr_q[L]);                          // R4
    AST_FRESH_ENTRY_LSB: assert property (@(posedge clk) disable iff (rst)
      (take_o && take_lvl_o == LW'(L) && !$past(isr_q[L])) |-> !ret_q[0]);     // R5
    AST_SELF_ENTRY: assert property (@(posedge clk) disable iff (rst)
      (take_o && take_lvl_o == LW'(L) && $past(isr_q[L])) |-> ($past(sn_q) && ret_q[0])); // R9
  end

  AST_GIE_DROP: assert property (@(posedge clk) disable iff (rst)
    take_o |-> !gie_q);                                                        // R7
  AST_KEEP_ON_LSB: assert property (@(posedge clk) disable iff (rst)
    (resume_o && $past(ret_q[0])) |-> (isr_q == $past(isr_q)));                // R10
  AST_RESUME_EVEN: assert property (@(posedge clk) disable iff (rst)
    resume_o |-> !resume_addr_o[0]);                                           // R10
  AST_ONE_EVENT: assert property (@(posedge clk) disable iff (rst)
    $onehot0({take_o, resume_o}));                                             // R11
endmodule

// File: tb/test_evt_ctrl.sv
`timescale 1ns/1ps
module test_evt_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] req_i = '0;
  logic        raise_i = 1'b0;
  logic [3:0]  raise_lvl_i = '0;
  logic        rti_i = 1'b0;
  logic [31:0] ret_addr_i = '0;
  logic        nest_en_i = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [6:0]  wr_addr_i = '0;
  logic [31:0] wr_data_i = '0;
  logic [6:0]  rd_addr_i = '0;
  logic [31:0] rd_data_o;
  logic        take_o;
  logic [3:0]  take_lvl_o;
  logic [31:0] take_vec_o;
  logic        resume_o;
  logic [31:0] resume_addr_o;

  int total = 0;
  int bad   = 0;

  always #10 clk = ~clk;   // 50 MHz

  evt_ctrl i_evt_ctrl (
    .clk(clk), .rst(rst), .req_i(req_i), .raise_i(raise_i),
    .raise_lvl_i(raise_lvl_i), .rti_i(rti_i), .ret_addr_i(ret_addr_i),
    .nest_en_i(nest_en_i), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o),
    .take_o(take_o), .take_lvl_o(take_lvl_o), .take_vec_o(take_vec_o),
    .resume_o(resume_o), .resume_addr_o(resume_addr_o)
  );

  function automatic logic [31:0] vecval(input int n);
    return 32'h8000_0000 | (n << 8) | (n << 2);
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    cyc();
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] d);
    rd_addr_i = a;
    cyc();
    d = rd_data_o;
  endtask

  task automatic raise(input int l);
    raise_i = 1'b1; raise_lvl_i = 4'(l);
    cyc();
    raise_i = 1'b0;
  endtask

  task automatic do_rti();
    rti_i = 1'b1;
    cyc();
    rti_i = 1'b0;
  endtask

  task automatic expect_take(input int l, input string tag);
    chk({31'b0, take_o}, 32'd1, tag);
    chk({28'b0, take_lvl_o}, 32'(l), tag);
    chk(take_vec_o, vecval(l), tag);
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) cyc();
    rst = 1'b0;
    cyc();

    // R1 reset state
    chk({31'b0, take_o}, 0, "R1 take_o");
    chk({31'b0, resume_o}, 0, "R1 resume_o");
    rd(7'h00, d); chk(d, 0, "R1 pending");
    rd(7'h04, d); chk(d, 0, "R1 mask");
    rd(7'h08, d); chk(d, 0, "R1 in-service");
    rd(7'h0C, d); chk(d, 1, "R1 control");

    // R12 vector table and return register access
    for (int n = 0; n < 16; n++) wr(7'(7'h40 + 4 * n), vecval(n));
    for (int n = 0; n < 16; n++) begin
      rd(7'(7'h40 + 4 * n), d); chk(d, vecval(n), "R12 vector readback");
    end
    wr(7'h10, 32'hDEAD_BEE5);
    rd(7'h10, d); chk(d, 32'hDEAD_BEE5, "R12 return reg");

    // R2 external lines and pending write
    req_i = 16'hA5A5; cyc(); req_i = '0;
    rd(7'h00, d); chk(d, 32'h0000_A5A5, "R2 req lines");
    wr(7'h00, 32'h0); rd(7'h00, d); chk(d, 0, "R2 pending write");

    // R3 masked raises stay pending, back-to-back raises accumulate (R2)
    for (int n = 0; n < 16; n++) begin
      raise(n);
      chk({31'b0, take_o}, 0, "R3 masked no take");
    end
    cyc(); chk({31'b0, take_o}, 0, "R3 masked no take");
    rd(7'h00, d); chk(d, 32'h0000_FFFF, "R2 all pending");
    wr(7'h00, 32'h0);

    // R4 R5 R11 sweep of every level
    wr(7'h04, 32'hFFFF);
    for (int n = 0; n < 16; n++) begin
      ret_addr_i = 32'h2000_0001 + 32'(n * 8);
      raise(n);
      cyc();
      expect_take(n, "R4 entry");
      rd(7'h08, d); chk(d, 32'(1 << n), "R4 in-service set");
      rd(7'h00, d); chk(d, 0, "R4 pending cleared");
      rd(7'h0C, d); chk(d, 0, "R4 gie cleared");
      rd(7'h10, d); chk(d, ret_addr_i & ~32'h1, "R5 saved address even");
      do_rti();
      chk({31'b0, resume_o}, 1, "R11 resume pulse");
      chk(resume_addr_o, ret_addr_i & ~32'h1, "R11 resume address");
      rd(7'h08, d); chk(d, 0, "R11 in-service cleared");
      rd(7'h0C, d); chk(d, 1, "R11 gie restored");
    end

    // R6 priority order among pending levels
    begin
      int order[4] = '{3, 5, 9, 12};
      wr(7'h04, 32'h0);
      raise(9); raise(3); raise(12); raise(5);
      wr(7'h04, 32'hFFFF);
      cyc(); expect_take(order[0], "R6 lowest first");
      for (int i = 1; i < 4; i++) begin
        do_rti(); cyc(); expect_take(order[i], "R6 order");
      end
      do_rti();
      rd(7'h08, d); chk(d, 0, "R6 all retired");
    end

    // R6 R7 R8 strict comparison, gating and no self re-entry
    ret_addr_i = 32'h3000_0040;
    raise(5); cyc(); expect_take(5, "R8 first entry");
    nest_en_i = 1'b1;
    raise(7); cyc(); chk({31'b0, take_o}, 0, "R6 less urgent held");
    raise(5); cyc(); chk({31'b0, take_o}, 0, "R8 no self re-entry");
    rd(7'h00, d); chk(d, 32'h0000_00A0, "R8 requests stay pending");
    nest_en_i = 1'b0;
    raise(2); cyc(); chk({31'b0, take_o}, 0, "R7 gated by gie");
    nest_en_i = 1'b1;
    cyc(); expect_take(2, "R7 nest enable preempts");
    do_rti(); cyc(); chk({31'b0, take_o}, 0, "R8 still in level 5");
    rd(7'h08, d); chk(d, 32'h0000_0020, "R11 only inner retired");
    do_rti(); cyc(); expect_take(5, "R8 taken after return");
    do_rti(); cyc(); expect_take(7, "R11 less urgent after return");
    do_rti();
    rd(7'h08, d); chk(d, 0, "R11 idle");
    nest_en_i = 1'b0;

    // R9 R10 self nesting enabled
    wr(7'h0C, 32'h5);
    ret_addr_i = 32'h5000_0008;
    raise(11); cyc(); expect_take(11, "R9 first entry");
    nest_en_i = 1'b1;
    raise(11); cyc(); expect_take(11, "R9 self re-entry");
    rd(7'h10, d); chk(d, 32'h5000_0009, "R9 return bit0 set");
    rd(7'h08, d); chk(d, 32'h0000_0800, "R9 in-service");
    do_rti();
    chk(resume_addr_o, 32'h5000_0008, "R10 resume bit0 clear");
    rd(7'h08, d); chk(d, 32'h0000_0800, "R10 in-service kept");
    wr(7'h10, 32'h5000_0100);
    do_rti();
    rd(7'h08, d); chk(d, 0, "R11 retired after even return");
    rd(7'h0C, d); chk(d, 5, "R9 control readback");
    wr(7'h0C, 32'h1);
    nest_en_i = 1'b0;

    // R10 software-set bit 0 with self nesting off
    raise(13); cyc(); expect_take(13, "R10 entry");
    wr(7'h10, 32'h4000_0011);
    do_rti();
    chk({31'b0, resume_o}, 1, "R10 resume pulse");
    chk(resume_addr_o, 32'h4000_0010, "R10 resume address");
    rd(7'h08, d); chk(d, 32'h0000_2000, "R10 kept with self-nest off");
    wr(7'h10, 32'h4000_0020);
    do_rti();
    rd(7'h08, d); chk(d, 0, "R11 final retire");

    summary();
    $finish;
  end
endmodule